// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings an SDRAM device from power-up to a usable state. After reset is released it raises the clock-enable line and counts a power-up wait whose length comes from parameters. A simulation build may shorten that wait. When the wait has elapsed, it hands four start-up commands in a fixed order to a separate command issuer. It holds back each command until the issuer has confirmed the one before it.

Each command is offered as a one-cycle request strobe together with an opcode. The opcode stays steady until the issuer pulses a done input. Once the issuer confirms the last command, the block raises a ready flag. That flag stays high until the next reset. Reset can be applied at any point, and it always restarts the whole sequence, including the full wait. Driving the SDRAM pins and choosing the mode register contents are left to other logic.

Top module: `sdram_boot_seq`

## Requirements
- R1: While reset is high (synchronous, active high), the block presents cmd_req low, cmd_op = NOP (2'b00), cke low and init_done low.
- R2: The power-up wait is W = ceil(POWERUP_WAIT_PS / CLK_PERIOD_PS) cycles, with a default wait of 100 µs. The first cmd_req appears exactly W rising edges after the first edge at which reset is low, and never earlier.
- R3: cke goes high on the first rising edge with reset low and stays high until reset.
- R4: Commands are issued in this order: precharge-all (2'b01), auto-refresh (2'b10), auto-refresh (2'b10), load-mode (2'b11).
- R5: cmd_req is high for exactly one cycle per command. cmd_op holds that command's code from the request until the command is acknowledged.
- R6: A command counts as acknowledged only when cmd_done is high at an edge after the edge that sampled its request. The next request appears on the cycle after that edge. A cmd_done during the wait, or in the same cycle as the request, has no effect.
- R7: While no command is outstanding (during the wait and after completion), cmd_op is NOP and cmd_req stays low.
- R8: init_done rises on the cycle after the load-mode command is acknowledged. It then stays high until reset, whatever cmd_done does.
- R9: Reset applied mid-sequence returns the block to the wait. After release, the full W-cycle wait and the full command order are repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_done | input | 1 | Issuer pulse: current command has been sent |
| cmd_req | output | 1 | One-cycle strobe offering a new command |
| cmd_op | output | 2 | Command code: 00 NOP, 01 precharge-all, 10 auto-refresh, 11 load-mode |
| cke | output | 1 | SDRAM clock enable |
| init_done | output | 1 | Start-up sequence complete |

## Verification
The first request is due exactly W edges after reset release, and cke is due on the first of those edges. Every later request and init_done are due one edge after an accepted cmd_done.

The bench drives inputs on falling edges and counts rising edges from each stimulus. It samples outputs at the following falling edge, so each check lands on the exact cycle the result is due. In the early cycles it checks that the output is still absent.

Random acknowledge delays, stray done pulses during the wait, a done in the same cycle as a request, and a reset in the middle of the sequence all probe that these timings stay put.

// File: rtl/sdram_boot_seq.sv
module sdram_boot_seq #(
  parameter int unsigned CLK_PERIOD_PS   = 5000,
  parameter int unsigned POWERUP_WAIT_PS = 100_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_done,
  output logic       cmd_req,
  output logic [1:0] cmd_op,
  output logic       cke,
  output logic       init_done
);
  localparam longint unsigned RAW_CYC =
    (longint'(POWERUP_WAIT_PS) + longint'(CLK_PERIOD_PS) - 1) / longint'(CLK_PERIOD_PS);
  localparam int unsigned WAIT_CYC = (RAW_CYC < 1) ? 1 : int'(RAW_CYC);
  localparam int unsigned CW = $clog2(WAIT_CYC + 1);

  typedef enum logic [2:0] {S_WAIT, S_PRE, S_REF1, S_REF2, S_LMR, S_DONE} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          issued;
  logic          in_cmd;

  assign in_cmd    = (st == S_PRE) || (st == S_REF1) || (st == S_REF2) || (st == S_LMR);
  assign cmd_req   = in_cmd && !issued;
  assign init_done = (st == S_DONE);

  always_comb begin
    case (st)
      S_PRE:          cmd_op = 2'b01;
      S_REF1, S_REF2: cmd_op = 2'b10;
      S_LMR:          cmd_op = 2'b11;
      default:        cmd_op = 2'b00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_WAIT;
      cnt    <= '0;
      issued <= 1'b0;
      cke    <= 1'b0;
    end else begin
      cke <= 1'b1;
      if (st == S_WAIT) begin
        if (cnt == CW'(WAIT_CYC - 1)) st <= S_PRE;
        else                          cnt <= cnt + 1'b1;
      end else if (in_cmd) begin
        if (!issued) begin
          issued <= 1'b1;
        end else if (cmd_done) begin
          issued <= 1'b0;
          case (st)
            S_PRE:   st <= S_REF1;
            S_REF1:  st <= S_REF2;
            S_REF2:  st <= S_LMR;
            default: st <= S_DONE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/sdram_boot_seq_chk.sv
module sdram_boot_seq_chk #(
  parameter int unsigned CLK_PERIOD_PS   = 5000,
  parameter int unsigned POWERUP_WAIT_PS = 100_000_000
) (
  input logic       clk,
  input logic       rst,
  input logic       cmd_done,
  input logic       cmd_req,
  input logic [1:0] cmd_op,
  input logic       cke,
  input logic       init_done
);
  localparam longint unsigned RAW_CYC =
    (longint'(POWERUP_WAIT_PS) + longint'(CLK_PERIOD_PS) - 1) / longint'(CLK_PERIOD_PS);
  localparam int unsigned WAIT_CYC = (RAW_CYC < 1) ? 1 : int'(RAW_CYC);
  localparam int unsigned CW = $clog2(WAIT_CYC + 2);

  logic [CW-1:0] since;
  always_ff @(posedge clk) begin
    if (rst) since <= '0;
    else if (since != CW'(WAIT_CYC)) since <= since + 1'b1;
  end

  a_r2_no_early_req: assert property (@(posedge clk) disable iff (rst)
    (since < CW'(WAIT_CYC)) |-> !cmd_req);
  a_r3_cke_held: assert property (@(posedge clk) disable iff (rst)
    cke |=> cke);
  a_r3_cmd_needs_cke: assert property (@(posedge clk) disable iff (rst)
    cmd_req |-> cke);
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    cmd_req |=> !cmd_req);
  a_r5_op_valid: assert property (@(posedge clk) disable iff (rst)
    cmd_req |-> (cmd_op != 2'b00));
  a_r5_op_hold: assert property (@(posedge clk) disable iff (rst)
    (cmd_req && !cmd_done) |=> $stable(cmd_op));
  a_r7_quiet_after: assert property (@(posedge clk) disable iff (rst)
    init_done |-> (!cmd_req && cmd_op == 2'b00));
  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);
endmodule

bind sdram_boot_seq sdram_boot_seq_chk #(
  .CLK_PERIOD_PS(CLK_PERIOD_PS), .POWERUP_WAIT_PS(POWERUP_WAIT_PS)
) chk_i (
  .clk(clk), .rst(rst), .cmd_done(cmd_done), .cmd_req(cmd_req),
  .cmd_op(cmd_op), .cke(cke), .init_done(init_done)
);

// File: tb/sdram_boot_seq_tb_top.sv
module sdram_boot_seq_tb_top;
  localparam int unsigned CLK_PS  = 5000;
  localparam int unsigned WAIT_PS = 201_000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_done = 1'b0;
  logic cmd_req, cke, init_done;
  logic [1:0] cmd_op;
  int total = 0, bad = 0;
  int unsigned seed = 32'h5eed;

  always #2.5ns clk = ~clk;

  sdram_boot_seq #(.CLK_PERIOD_PS(CLK_PS), .POWERUP_WAIT_PS(WAIT_PS)) dut_i (
    .clk(clk), .rst(rst), .cmd_done(cmd_done), .cmd_req(cmd_req),
    .cmd_op(cmd_op), .cke(cke), .init_done(init_done));

  function automatic int exp_wait(int unsigned w, int unsigned p);
    return int'((w + p - 1) / p);
  endfunction

  function automatic logic [1:0] exp_op(int k);
    case (k)
      0:       return 2'b01;
      1, 2:    return 2'b10;
      default: return 2'b11;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1ns;
    @(negedge clk);
  endtask

  task automatic do_reset(int n);
    rst = 1'b1; cmd_done = 1'b0;
    for (int i = 0; i < n; i++) begin
      tick();
      chk("R1 req", cmd_req, 0); chk("R1 op", cmd_op, 0);
      chk("R1 cke", cke, 0);     chk("R1 done", init_done, 0);
    end
    rst = 1'b0;
  endtask

  task automatic wait_phase(bit noise);
    int seen = 0;
    for (int i = 1; i <= 200 && seen == 0; i++) begin
      cmd_done = noise && ($urandom(seed) % 3 == 0) && (i < exp_wait(WAIT_PS, CLK_PS) - 1);
      if (i > 1) seed = seed + 1;
      tick();
      if (i == 1) chk("R3 cke rise", cke, 1);
      if (cmd_req) seen = i;
      else if (i < exp_wait(WAIT_PS, CLK_PS)) chk("R7 idle op", cmd_op, 0);
    end
    cmd_done = 1'b0;
    chk("R2 first request cycle", seen, exp_wait(WAIT_PS, CLK_PS));
  endtask

  task automatic run_cmds(int upto, bit same_cycle_done);
    for (int k = 0; k < upto; k++) begin
      chk("R4 order", cmd_op, exp_op(k));
      chk("R5 req high", cmd_req, 1);
      if (k == 0 && same_cycle_done) begin
        cmd_done = 1'b1; tick(); cmd_done = 1'b0;
        chk("R6 same-cycle done ignored op", cmd_op, exp_op(0));
        chk("R6 same-cycle done ignored done", init_done, 0);
      end else begin
        tick();
      end
      chk("R5 req one cycle", cmd_req, 0);
      for (int d = 0; d < int'($urandom(seed) % 4); d++) begin
        tick();
        chk("R5 op held", cmd_op, exp_op(k));
        chk("R5 no re-request", cmd_req, 0);
      end
      cmd_done = 1'b1; tick(); cmd_done = 1'b0;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset(3);
    wait_phase(1'b1);
    run_cmds(4, 1'b1);
    chk("R8 done after LMR ack", init_done, 1);
    chk("R7 op NOP after done", cmd_op, 0);
    for (int i = 0; i < 6; i++) begin
      cmd_done = $urandom(seed) % 2; tick();
      chk("R8 done sticky", init_done, 1);
      chk("R7 no req after done", cmd_req, 0);
    end
    cmd_done = 1'b0;
    do_reset(2);
    wait_phase(1'b0);
    run_cmds(2, 1'b0);
    chk("R9 mid-sequence op", cmd_op, exp_op(2));
    do_reset(2);
    wait_phase(1'b1);
    run_cmds(4, 1'b0);
    chk("R9 restart completes", init_done, 1);
    for (int r = 0; r < 3; r++) begin
      do_reset(1 + int'($urandom(seed) % 3));
      wait_phase(1'b1);
      run_cmds(4, r[0]);
      chk("R8 random run done", init_done, 1);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule